// File: doc/BRIEF.md
# Selectable-Source Clock Divider Cell

This cell produces a divided, gated tick stream from one of several source tick strobes. A bypass reference and up to eight alternative sources arrive as one-cycle strobes on the common system clock. A two-level selector chooses among them. A first switch picks either the bypass reference or the indexed mux, and a 3-bit index then chooses the alternative source. The selected ticks are counted, and one output tick is emitted on every Nth source tick. N comes from a non-linear programmable table, from a fixed divide-by-3 path that overrides that table, or is 1 when the divider is bypassed.

A gate bit passes or blocks the divided ticks. A square-wave output toggles on each emitted tick. All control sits in one 10-bit register, which is written through a simple write port and read back unchanged. New settings take effect only when the divider wraps, so an output period is never cut short. The exception is while the cell is gated off: then new settings apply at once. The parameters `HAS_GATE` and `HAS_MUX` remove the gate or the source mux from an instance. In that case the cell acts as always enabled or always on the bypass reference.

Top module: `clkdiv_cell`

## Requirements
- R1: A synchronous active-high reset clears the configuration to 0. It also holds `div_tick` and `sq_out` at 0 and sets `ratio_out` to 1.
- R2: `cfg_rdata` returns the last value written with `cfg_we`, all 10 bits unchanged. The field layout is: bit 0 gate, bits 3:1 source index, bit 4 source switch, bit 5 divider switch, bit 6 divide-by-3 switch, bits 9:7 divide select.
- R3: With bit 4 at 0 the cell counts `ref_tick` and ignores the index. With bit 4 at 1 it counts `alt_tick[index]`, and every other source is ignored.
- R4: With bit 6 at 0 and bit 5 at 1, divide-select codes 0 through 7 give ratios 1, 2, 4, 6, 8, 12, 1 and 1.
- R5: Bit 6 at 1 forces a ratio of 3, whatever bits 5 and 9:7 hold.
- R6: Bit 6 at 0 together with bit 5 at 0 gives a ratio of 1.
- R7: `div_tick` pulses for one cycle after every Nth counted source tick, in the cycle after that source tick is sampled. `ratio_out` reports the N in force.
- R8: While the applied gate is 0, `div_tick` stays 0 and `sq_out` stays 0.
- R9: While running, a change of ratio, source or gate takes effect only at the source tick that completes the current period. While gated off, a change applies on the next clock edge and the count restarts from zero.
- R10: `sq_out` toggles with each `div_tick`. If the gate is switched off at that tick, `sq_out` goes to 0 instead.
- R11: With `HAS_GATE=0` the cell acts as permanently enabled, and with `HAS_MUX=0` it always counts `ref_tick`. In both cases the unused bits still read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration write value |
| cfg_rdata | output | 10 | Configuration read-back |
| ref_tick | input | 1 | Bypass reference tick strobe |
| alt_tick | input | NALT | Alternative source tick strobes |
| div_tick | output | 1 | Divided, gated output tick |
| sq_out | output | 1 | Square wave toggling on each output tick |
| ratio_out | output | 4 | Ratio currently applied |

## Verification
Directed runs drive a dense reference stream for each kind of ratio: the divide-by-3 override, the bypassed divider, and table code 5 (ratio 12). Counting output ticks over a known number of source ticks shows whether each ratio is applied. A run with competing alternative sources shows whether the index selects the right strobe and whether the bypass switch is obeyed. A mid-period ratio change shows that settings are deferred to the wrap. A gated-off run, with a second instance built without gate and mux, shows the difference between blocking the gate and ignoring the gate. Random phases with sparse writes and random tick density compare every output each cycle against a bench model of the requirements.

// File: rtl/clkdiv_cell.sv
module clkdiv_cell #(
  parameter bit HAS_GATE = 1'b1,
  parameter bit HAS_MUX  = 1'b1,
  parameter int NALT     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [9:0]      cfg_wdata,
  output logic [9:0]      cfg_rdata,
  input  logic            ref_tick,
  input  logic [NALT-1:0] alt_tick,
  output logic            div_tick,
  output logic            sq_out,
  output logic [3:0]      ratio_out
);
  localparam int IDXW = 3;

  function automatic logic [3:0] ratio_of(input logic [9:0] c);
    if (c[6]) return 4'd3;
    if (!c[5]) return 4'd1;
    case (c[9:7])
      3'd0: return 4'd1;
      3'd1: return 4'd2;
      3'd2: return 4'd4;
      3'd3: return 4'd6;
      3'd4: return 4'd8;
      3'd5: return 4'd12;
      default: return 4'd1;
    endcase
  endfunction

  logic [9:0]      cfg_q;
  logic            act_gate, act_sw;
  logic [IDXW-1:0] act_idx;
  logic [3:0]      act_ratio, cnt;
  logic            sq_q, tick_q;

  wire want_gate = HAS_GATE ? cfg_q[0] : 1'b1;
  wire want_sw   = HAS_MUX  ? cfg_q[4] : 1'b0;
  wire alt_sel   = (32'(act_idx) < NALT) ? alt_tick[act_idx] : 1'b0;
  wire src_tick  = act_sw ? alt_sel : ref_tick;
  wire wrap      = (cnt == act_ratio - 4'd1);
  wire period_end = act_gate && src_tick && wrap;
  wire load      = !act_gate || period_end;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_gate  <= 1'b0;
      act_sw    <= 1'b0;
      act_idx   <= '0;
      act_ratio <= 4'd1;
    end else if (load) begin
      act_gate  <= want_gate;
      act_sw    <= want_sw;
      act_idx   <= cfg_q[3:1];
      act_ratio <= ratio_of(cfg_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !act_gate) cnt <= '0;
    else if (src_tick) cnt <= wrap ? 4'd0 : cnt + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= 1'b0;
      sq_q   <= 1'b0;
    end else begin
      tick_q <= period_end;
      if (period_end) sq_q <= want_gate ? ~sq_q : 1'b0;
    end
  end

  assign cfg_rdata = cfg_q;
  assign div_tick  = tick_q;
  assign sq_out    = sq_q;
  assign ratio_out = act_ratio;

  p_gated_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !act_gate |=> !div_tick);
  p_ratio_legal_r4: assert property (@(posedge clk) disable iff (rst)
    ratio_out inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12});
  p_sq_moves_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (sq_out != $past(sq_out)) |-> div_tick);
  p_hold_midperiod_r9: assert property (@(posedge clk) disable iff (rst)
    (act_gate && !(src_tick && wrap)) |=> $stable(ratio_out));
  p_div3_override_r5: assert property (@(posedge clk) disable iff (rst)
    (load && cfg_q[6]) |=> (ratio_out == 4'd3));
endmodule

// File: tb/clkdiv_cell_tb_top.sv
module clkdiv_cell_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic ref_tick = 1'b0;
  logic [7:0] alt_tick = '0;
  logic [9:0] rd0, rd1;
  logic dt0, dt1, sq0, sq1;
  logic [3:0] ra0, ra1;
  int n_chk = 0, n_bad = 0, cnt0 = 0, cnt1 = 0;

  always #4 clk = ~clk;

  clkdiv_cell #(.HAS_GATE(1'b1), .HAS_MUX(1'b1), .NALT(8)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd0),
    .ref_tick(ref_tick), .alt_tick(alt_tick), .div_tick(dt0), .sq_out(sq0), .ratio_out(ra0));
  clkdiv_cell #(.HAS_GATE(1'b0), .HAS_MUX(1'b0), .NALT(8)) dut_nm (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd1),
    .ref_tick(ref_tick), .alt_tick(alt_tick), .div_tick(dt1), .sq_out(sq1), .ratio_out(ra1));

  typedef struct packed {
    logic [9:0] cfg; logic ag; logic asw; logic [2:0] aidx;
    logic [3:0] ar; logic [3:0] cnt; logic tk; logic sq;
  } mst_t;
  mst_t m0, m1;

  function automatic logic [3:0] exp_ratio(input logic [9:0] c);
    logic [3:0] tbl [8] = '{4'd1, 4'd2, 4'd4, 4'd6, 4'd8, 4'd12, 4'd1, 4'd1};
    if (c[6]) return 4'd3;
    if (!c[5]) return 4'd1;
    return tbl[c[9:7]];
  endfunction

  function automatic mst_t mreset();
    mst_t s = '0; s.ar = 4'd1; return s;
  endfunction

  function automatic mst_t mstep(input mst_t s, input bit hg, input bit hm,
      input logic we, input logic [9:0] wd, input logic rt, input logic [7:0] at);
    mst_t n = s;
    logic g = hg ? s.cfg[0] : 1'b1;
    logic src = s.asw ? at[s.aidx] : rt;
    logic done = s.ag && src && (s.cnt == s.ar - 4'd1);
    n.tk = done;
    if (done) n.sq = g ? ~s.sq : 1'b0;
    if (!s.ag || done) begin
      n.ag = g; n.asw = hm ? s.cfg[4] : 1'b0; n.aidx = s.cfg[3:1]; n.ar = exp_ratio(s.cfg);
    end
    if (!s.ag) n.cnt = 0;
    else if (src) n.cnt = done ? 4'd0 : s.cnt + 4'd1;
    if (we) n.cfg = wd;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [9:0] wd, input logic rt, input logic [7:0] at);
    cfg_we = we; cfg_wdata = wd; ref_tick = rt; alt_tick = at;
    @(posedge clk);
    if (rst) begin m0 = mreset(); m1 = mreset(); end
    else begin
      m0 = mstep(m0, 1'b1, 1'b1, we, wd, rt, at);
      m1 = mstep(m1, 1'b0, 1'b0, we, wd, rt, at);
    end
    @(negedge clk);
    if (!rst) begin
      chk(dt0 == m0.tk, "R7 div_tick", dt0, m0.tk);
      chk(sq0 == m0.sq, "R10 sq_out", sq0, m0.sq);
      chk(ra0 == m0.ar, "R4 ratio_out", ra0, m0.ar);
      chk(rd0 == m0.cfg, "R2 readback", rd0, m0.cfg);
      chk(dt1 == m1.tk, "R11 nm div_tick", dt1, m1.tk);
      chk(rd1 == m1.cfg, "R11 nm readback", rd1, m1.cfg);
    end
    cnt0 += dt0; cnt1 += dt1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(1'b0, '0, 1'b0, '0); cyc(1'b0, '0, 1'b0, '0);
    rst = 1'b0;
  endtask

  task automatic setup(input logic [9:0] c);
    cyc(1'b1, c, 1'b0, '0); cyc(1'b0, '0, 1'b0, '0);
    cnt0 = 0; cnt1 = 0;
  endtask

  task automatic ticks(input int n, input logic [7:0] at);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b1, at);
    cyc(1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m0 = mreset(); m1 = mreset();
    @(negedge clk);
    do_reset();
    chk(rd0 == 10'd0 && dt0 == 1'b0 && sq0 == 1'b0, "R1 reset outputs", rd0, 0);
    chk(ra0 == 4'd1, "R1 reset ratio", ra0, 1);

    setup(10'h041); ticks(9, '0);
    chk(cnt0 == 3, "R5 div3 override count", cnt0, 3);
    chk(ra0 == 4'd3, "R5 ratio", ra0, 3);

    do_reset(); setup(10'h3C1); ticks(9, '0);
    chk(cnt0 == 3, "R5 div3 beats select", cnt0, 3);

    do_reset(); setup(10'h281); ticks(5, '0);
    chk(cnt0 == 5 && ra0 == 4'd1, "R6 divider bypass", cnt0, 5);

    do_reset(); setup(10'h2A1); ticks(24, '0);
    chk(cnt0 == 2 && ra0 == 4'd12, "R4 code5 ratio 12", cnt0, 2);

    do_reset(); setup(10'h01B);
    for (int i = 0; i < 12; i++) cyc(1'b0, '0, 1'b1, (i % 3 == 0) ? 8'h24 : 8'h04);
    cyc(1'b0, '0, 1'b0, '0);
    chk(cnt0 == 4, "R3 alt index 5 only", cnt0, 4);
    chk(cnt1 == 12, "R11 no mux uses ref", cnt1, 12);

    do_reset(); setup(10'h000); ticks(10, '0);
    chk(cnt0 == 0 && sq0 == 1'b0, "R8 gated off", cnt0, 0);
    chk(cnt1 == 10, "R11 no gate always on", cnt1, 10);

    do_reset(); setup(10'h2A1);
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, '0);
    cyc(1'b1, 10'h001, 1'b0, '0);
    cnt0 = 0; ticks(9, '0);
    chk(cnt0 == 1, "R9 deferred change", cnt0, 1);
    chk(ra0 == 4'd1, "R9 new ratio at wrap", ra0, 1);
    ticks(3, '0);
    chk(cnt0 == 4, "R7 ratio 1 after wrap", cnt0, 4);

    cyc(1'b1, 10'h000, 1'b0, '0);
    cyc(1'b0, '0, 1'b1, '0); cyc(1'b0, '0, 1'b0, '0);
    chk(sq0 == 1'b0, "R10 gate off drops square", sq0, 0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 20000; i++) begin
      logic w = ($urandom % 40) == 0;
      logic [9:0] d = 10'($urandom);
      logic r = ($urandom % 3) != 0;
      logic [7:0] a = 8'($urandom);
      if (($urandom % 4000) == 0) do_reset();
      cyc(w, d, r, a);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule